// File: doc/BRIEF.md
# MAC Configuration Register Bridge

This block places a bank of slow 16-bit MAC configuration registers behind two 32-bit host registers: a command register and a data register. The host never addresses the internal registers directly. To change one, it first loads the data register and then writes the command register with the target index and the write flag set. To read one, it writes the command register with the write flag clear and picks up the result from the data register once the access has finished.

Every internal access takes a fixed number of core clocks, set by a parameter. During that window a busy bit in the command register reads as one. Commands and data loads that arrive while the bridge is busy are dropped, so the pending access completes exactly as it was issued. The bank holds a mode register (receive, transmit, gigabit and flow-control enables), a receive/transmit control word and three words of station address. Their contents drive the MAC configuration outputs continuously.

Top module: `mac_cfg_bridge`

## Requirements
- R1: After reset the mode register holds only the flow-control enable bit (value 0x0008). The control word, all three address words, the data register and the command register read zero, and busy is clear.
- R2: A write access loads the data register (hostRegSel=1) and then writes the command register (hostRegSel=0) with bit 31 set and the index in bits [IDX_W-1:0]. ACCESS_CYCLES clock edges later, the indexed register holds bits [15:0] of the data register.
- R3: A read access writes the command register with bit 31 clear. ACCESS_CYCLES clock edges later, the data register reads {16'h0000, selected register}.
- R4: Bit 30 of the command register reads 1 for exactly ACCESS_CYCLES cycles, starting in the cycle after an accepted command, and 0 otherwise.
- R5: A command register write while busy is ignored. The pending access completes with its original index and direction, and no second access follows.
- R6: A data register write while busy is ignored, so a pending write commits the value loaded before the command.
- R7: Indices 5 and above are unmapped. They read as zero, and writes to them change no register.
- R8: Index 2, 3 and 4 hold the station address. Octet 0 is the high byte of index 2 and appears on stationAddr[47:40]. The following octets follow in order down to octet 5, which is the low byte of index 4 on stationAddr[7:0].
- R9: Mode register index 0 uses bit 0 for receive enable, bit 1 for transmit enable, bit 2 for gigabit enable and bit 3 for flow-control enable. Its other bits read zero. Each enable drives its own output.
- R10: Control word index 1 is fully writable as 16 bits and drives rxtxCtrl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe for the selected host register |
| hostRegSel | input | 1 | Host register select: 0 = command, 1 = data |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Selected host register contents |
| macRxEn | output | 1 | Receive enable from the mode register |
| macTxEn | output | 1 | Transmit enable from the mode register |
| macGigEn | output | 1 | Gigabit enable from the mode register |
| macFlowEn | output | 1 | Flow-control enable from the mode register |
| rxtxCtrl | output | 16 | Receive/transmit control word |
| stationAddr | output | 48 | Station address, octet 0 in the top byte |

## Verification
The bench builds the bridge with ACCESS_CYCLES set to 5 and IDX_W set to 8. The short latency lets the bench sample the busy bit on every cycle of the access window and count the exact edge on which it drops. It also keeps the runs of mid-access command and data writes short. An 8-bit index reaches index 9, an unmapped slot, so the read-as-zero and write-ignored paths are exercised next to the mapped registers.

// File: rtl/macbr_pkg.sv
package macbr_pkg;

  // Strobes from the sequencer to the register datapath.
  typedef struct packed {
    logic latchCmd;     // accept a command: capture index and start the window
    logic acceptData;   // accept a host load of the data register
    logic commitWrite;  // end of a write access: update the bank
    logic captureRead;  // end of a read access: load the data register
  } seqStrobes_t;

  // Command register layout.
  localparam int unsigned CMD_WRITE_BIT = 31;
  localparam int unsigned CMD_BUSY_BIT  = 30;

  // Bank map.
  localparam int unsigned IDX_MODE    = 0;
  localparam int unsigned IDX_CTRL    = 1;
  localparam int unsigned IDX_ADDR0   = 2;
  localparam int unsigned ADDR_WORDS  = 3;
  localparam int unsigned BANK_SLOTS  = IDX_ADDR0 + ADDR_WORDS;

  // Mode register fields.
  localparam int unsigned MODE_BITS    = 4;
  localparam int unsigned MODE_RX_BIT  = 0;
  localparam int unsigned MODE_TX_BIT  = 1;
  localparam int unsigned MODE_GIG_BIT = 2;
  localparam int unsigned MODE_FC_BIT  = 3;
  localparam logic [MODE_BITS-1:0] MODE_RESET = 4'b1000;

endpackage

// File: rtl/macbr_seq.sv
module macbr_seq
  import macbr_pkg::*;
#(
  parameter int unsigned ACCESS_CYCLES = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic        hostRegSel,
  input  logic        cmdWrFlag,
  output seqStrobes_t strb,
  output logic        busy
);

  localparam int unsigned CNT_W = (ACCESS_CYCLES < 2) ? 1 : $clog2(ACCESS_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYCLES - 1);

  logic [CNT_W-1:0] remaining;
  logic             opWrite;
  logic             doneNow;

  always_comb begin
    doneNow          = busy && (remaining == '0);
    strb.latchCmd    = hostWr && !hostRegSel && !busy;
    strb.acceptData  = hostWr &&  hostRegSel && !busy;
    strb.commitWrite = doneNow &&  opWrite;
    strb.captureRead = doneNow && !opWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
      opWrite   <= 1'b0;
    end else if (strb.latchCmd) begin
      busy      <= 1'b1;
      remaining <= CNT_LOAD;
      opWrite   <= cmdWrFlag;
    end else if (doneNow) begin
      busy      <= 1'b0;
    end else if (busy) begin
      remaining <= remaining - 1'b1;
    end
  end

  // Checker: length of the current busy run.
  logic [CNT_W:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchCmd |=> busy);

  assert_hold_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneNow) |=> busy);

  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(busyRun) == (CNT_W+1)'(ACCESS_CYCLES - 1)));

  assert_single_action_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchCmd, strb.commitWrite, strb.captureRead}));

endmodule

// File: rtl/macbr_regs.sv
module macbr_regs
  import macbr_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobes_t          strb,
  input  logic                 busy,
  input  logic                 hostRegSel,
  input  logic [31:0]          hostWdata,
  output logic [31:0]          hostRdata,
  output logic [MODE_BITS-1:0] modeBits,
  output logic [15:0]          ctrlWord,
  output logic [47:0]          stationAddr
);

  logic [IDX_W-1:0] cmdIdx;
  logic [31:0]      dataReg;
  logic [15:0]      addrWord [ADDR_WORDS];
  logic [15:0]      bankRead;
  logic             idxMapped;

  // Command index capture.
  always_ff @(posedge clk) begin
    if (!rstN)              cmdIdx <= '0;
    else if (strb.latchCmd) cmdIdx <= hostWdata[IDX_W-1:0];
  end

  // Data register: host load when idle, read result at the end of a read.
  always_ff @(posedge clk) begin
    if (!rstN)                 dataReg <= '0;
    else if (strb.acceptData)  dataReg <= hostWdata;
    else if (strb.captureRead) dataReg <= {16'h0000, bankRead};
  end

  // Mode register.
  always_ff @(posedge clk) begin
    if (!rstN) modeBits <= MODE_RESET;
    else if (strb.commitWrite && cmdIdx == IDX_W'(IDX_MODE))
      modeBits <= dataReg[MODE_BITS-1:0];
  end

  // Receive/transmit control word.
  always_ff @(posedge clk) begin
    if (!rstN) ctrlWord <= '0;
    else if (strb.commitWrite && cmdIdx == IDX_W'(IDX_CTRL))
      ctrlWord <= dataReg[15:0];
  end

  // Station address words.
  for (genvar g = 0; g < ADDR_WORDS; g++) begin : gAddr
    always_ff @(posedge clk) begin
      if (!rstN) addrWord[g] <= '0;
      else if (strb.commitWrite && cmdIdx == IDX_W'(IDX_ADDR0 + g))
        addrWord[g] <= dataReg[15:0];
    end
  end

  assign stationAddr = {addrWord[0], addrWord[1], addrWord[2]};

  // Bank read selection; unmapped slots give zero.
  always_comb begin
    bankRead  = '0;
    idxMapped = (cmdIdx < IDX_W'(BANK_SLOTS));
    if (cmdIdx == IDX_W'(IDX_MODE)) bankRead = {{(16-MODE_BITS){1'b0}}, modeBits};
    if (cmdIdx == IDX_W'(IDX_CTRL)) bankRead = ctrlWord;
    for (int w = 0; w < ADDR_WORDS; w++)
      if (cmdIdx == IDX_W'(IDX_ADDR0 + w)) bankRead = addrWord[w];
  end

  // Host read mux.
  always_comb begin
    if (hostRegSel) begin
      hostRdata = dataReg;
    end else begin
      hostRdata = '0;
      hostRdata[CMD_BUSY_BIT] = busy;
      hostRdata[IDX_W-1:0]    = cmdIdx;
    end
  end

  assert_idx_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchCmd |=> $stable(cmdIdx));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.captureRead) |=> $stable(dataReg));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.captureRead && !idxMapped) |=> (dataReg == 32'h0));

  assert_mode_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite && cmdIdx == IDX_W'(IDX_MODE)) |=> (modeBits == $past(dataReg[MODE_BITS-1:0])));

  assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite && !idxMapped) |=> ($stable(modeBits) && $stable(ctrlWord) && $stable(stationAddr)));

endmodule

// File: rtl/mac_cfg_bridge.sv
module mac_cfg_bridge
  import macbr_pkg::*;
#(
  parameter int unsigned ACCESS_CYCLES = 50,
  parameter int unsigned IDX_W         = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic        hostRegSel,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        macRxEn,
  output logic        macTxEn,
  output logic        macGigEn,
  output logic        macFlowEn,
  output logic [15:0] rxtxCtrl,
  output logic [47:0] stationAddr
);

  seqStrobes_t          strb;
  logic                 busy;
  logic [MODE_BITS-1:0] modeBits;

  macbr_seq #(.ACCESS_CYCLES(ACCESS_CYCLES)) uSeq (
    .clk        (clk),
    .rstN       (rstN),
    .hostWr     (hostWr),
    .hostRegSel (hostRegSel),
    .cmdWrFlag  (hostWdata[CMD_WRITE_BIT]),
    .strb       (strb),
    .busy       (busy)
  );

  macbr_regs #(.IDX_W(IDX_W)) uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busy        (busy),
    .hostRegSel  (hostRegSel),
    .hostWdata   (hostWdata),
    .hostRdata   (hostRdata),
    .modeBits    (modeBits),
    .ctrlWord    (rxtxCtrl),
    .stationAddr (stationAddr)
  );

  assign macRxEn   = modeBits[MODE_RX_BIT];
  assign macTxEn   = modeBits[MODE_TX_BIT];
  assign macGigEn  = modeBits[MODE_GIG_BIT];
  assign macFlowEn = modeBits[MODE_FC_BIT];

endmodule

// File: tb/tb_mac_cfg_bridge.sv
module tb_mac_cfg_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 5;
  localparam int NVEC       = 11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRegSel = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        macRxEn, macTxEn, macGigEn, macFlowEn;
  logic [15:0] rxtxCtrl;
  logic [47:0] stationAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_cfg_bridge #(.ACCESS_CYCLES(LAT), .IDX_W(8)) dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRegSel(hostRegSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .macRxEn(macRxEn), .macTxEn(macTxEn), .macGigEn(macGigEn), .macFlowEn(macFlowEn),
    .rxtxCtrl(rxtxCtrl), .stationAddr(stationAddr)
  );

  // {write, index, data, expected data register after the access}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 8'd0, 32'hFFFF_FFF5, 32'hFFFF_FFF5},
    {1'b0, 8'd0, 32'h0000_0000, 32'h0000_0005},
    {1'b1, 8'd1, 32'h1234_ABCD, 32'h1234_ABCD},
    {1'b0, 8'd1, 32'h0000_0000, 32'h0000_ABCD},
    {1'b1, 8'd2, 32'h0000_ACDE, 32'h0000_ACDE},
    {1'b1, 8'd3, 32'h0000_4800, 32'h0000_4800},
    {1'b1, 8'd4, 32'h0000_0080, 32'h0000_0080},
    {1'b0, 8'd4, 32'h0000_0000, 32'h0000_0080},
    {1'b1, 8'd9, 32'h0000_5555, 32'h0000_5555},
    {1'b0, 8'd9, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 8'd2, 32'h0000_0000, 32'h0000_ACDE}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostPut(input logic sel, input logic [31:0] val);
    @(negedge clk);
    hostRegSel = sel;
    hostWdata  = val;
    hostWr     = 1'b1;
    @(negedge clk);
    hostWr     = 1'b0;
  endtask

  task automatic readData(output logic [31:0] v);
    hostRegSel = 1'b1;
    #1;
    v = hostRdata;
  endtask

  task automatic readCmd(output logic [31:0] v);
    hostRegSel = 1'b0;
    #1;
    v = hostRdata;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    readCmd(v);  check("R1 command reg", 64'(v), 64'h0);
    readData(v); check("R1 data reg", 64'(v), 64'h0);
    check("R1 mode outputs", 64'({macFlowEn, macGigEn, macTxEn, macRxEn}), 64'h8);
    check("R1 ctrl/addr", 64'({rxtxCtrl, stationAddr}), 64'h0);

    // R2 / R3: table of accesses
    for (int i = 0; i < NVEC; i++) begin
      logic        wr;
      logic [7:0]  idx;
      logic [31:0] dat, exp;
      {wr, idx, dat, exp} = VEC[i];
      if (wr) hostPut(1'b1, dat);
      hostPut(1'b0, {wr, 23'd0, idx});
      repeat (LAT) @(negedge clk);
      readData(v);
      check(wr ? "R2 write row" : "R3 read row (R7 when unmapped)", 64'(v), 64'(exp));
    end

    // R7 (unmapped write had no effect), R8, R9, R10
    check("R8 station address order", 64'(stationAddr), 64'hACDE_4800_0080);
    check("R9 mode enables", 64'({macFlowEn, macGigEn, macTxEn, macRxEn}), 64'h5);
    check("R10 control word", 64'(rxtxCtrl), 64'hABCD);

    // R4: busy window length
    hostPut(1'b0, {1'b0, 23'd0, 8'd1});
    for (int k = 0; k < LAT; k++) begin
      readCmd(v);
      check("R4 busy during access", 64'(v[30]), 64'h1);
      @(negedge clk);
    end
    readCmd(v);
    check("R4 busy clear after access", 64'(v[30]), 64'h0);

    // R5: command while busy ignored
    hostPut(1'b0, {1'b0, 23'd0, 8'd1});
    hostPut(1'b0, {1'b1, 23'd0, 8'd0});
    repeat (LAT) @(negedge clk);
    readData(v);
    check("R5 first read completes", 64'(v), 64'hABCD);
    check("R5 mode untouched", 64'({macFlowEn, macGigEn, macTxEn, macRxEn}), 64'h5);
    readCmd(v);
    check("R5 index kept and idle", 64'(v), 64'h1);

    // R6: data write while busy ignored
    hostPut(1'b1, 32'h0000_1111);
    hostPut(1'b0, {1'b1, 23'd0, 8'd1});
    hostPut(1'b1, 32'h0000_2222);
    repeat (LAT) @(negedge clk);
    check("R6 pending write value", 64'(rxtxCtrl), 64'h1111);
    readData(v);
    check("R6 data reg unchanged", 64'(v), 64'h1111);

    finish();
  end

endmodule